// File: doc/BRIEF.md
# Single-Byte Instruction Sequencer Core

This block is a minimal single-issue processor for a three-operation instruction set in which every instruction is one byte. It fetches from a 32-byte instruction store addressed by a 5-bit program counter. There is no address translation. Each clock cycle it decodes one instruction and retires it. Execution starts at address 0 after reset.

The core holds four 8-bit general registers and one zero flag. A compare takes the bitwise AND of two registers and records in the flag whether the result was all zeros. A conditional jump redirects the program counter to an absolute 5-bit address while the flag is clear. A no-op only moves to the next byte. The remaining opcode values act as no-ops and raise a one-cycle illegal-opcode pulse.

Two write ports load the instruction store and the registers, for test use. A registered trace reports the address and opcode of the instruction that has just retired.

Top module: `byte_isa_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the core sets `pcNow` to 0, `flagZero` to 1, `traceValid` to 0, `illegalOp` to 0, `tracePc` to 0 and `traceOp` to 0. Reset does not clear the instruction store or the registers.
- R2: Out of reset, the core retires the byte at `pcNow` at each clock edge. The following cycle shows `traceValid`=1, `tracePc` set to that address and `traceOp` set to bits [7:5] of that byte. A no-op (opcode 3'b011) leaves the flag unchanged and advances the PC by 1.
- R3: A compare has opcode 3'b001, with register A in bits [4:3] and register B in bits [2:1]. The register codes are 0 to 3 for r0 to r3, and bit 0 is zero. A compare sets the flag to 1 when (A & B) is 0 and clears it otherwise. It writes no register and advances the PC by 1.
- R4: A conditional jump has opcode 3'b010, with an absolute target in bits [4:0]. It loads the target into the PC when the flag is 0 and otherwise advances the PC by 1. A jump never changes the flag.
- R5: Every PC increment wraps from 31 to 0.
- R6: Opcodes 3'b000 and 3'b100 to 3'b111 act as no-ops. They leave the flag unchanged and advance the PC by 1. In the cycle in which their trace is shown, they also raise `illegalOp` for exactly that one cycle.
- R7: A store write (`memWrEn`) or a register write (`regWrEn`) takes effect at the clock edge. It is accepted during reset as well. An instruction retiring at the same edge sees the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memWrEn | input | 1 | Instruction-store write strobe |
| memWrAddr | input | 5 | Instruction-store write address |
| memWrData | input | 8 | Instruction byte to write |
| regWrEn | input | 1 | Register-initialisation write strobe |
| regWrIdx | input | 2 | Register index to write |
| regWrData | input | 8 | Register value to write |
| pcNow | output | 5 | Address of the next instruction to retire |
| flagZero | output | 1 | Zero flag from the most recent compare |
| traceValid | output | 1 | An instruction retired at the last edge |
| tracePc | output | 5 | Address of the retired instruction |
| traceOp | output | 3 | Opcode of the retired instruction |
| illegalOp | output | 1 | The retired opcode was unassigned |

## Verification
A test-port write and the execution of an instruction can land on the same edge. This happens when a register is rewritten while a compare that reads it is being retired, and when the byte under the PC is overwritten while it is being fetched. The bench provokes the first case on purpose in a scripted program. Both cases then recur many times in a phase with random writes. A reference model that reads all operands before applying any write judges the result, so a core that forwards the new value shows a different flag or PC.

// File: rtl/byte_isa_pkg.sv
`timescale 1ns/1ps
package byte_isa_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int NUM_REG = 4;
  localparam int IDX_W   = $clog2(NUM_REG);
  localparam int OP_W    = 3;

  localparam logic [OP_W-1:0] OP_CMP = 3'b001;
  localparam logic [OP_W-1:0] OP_JMP = 3'b010;
  localparam logic [OP_W-1:0] OP_NOP = 3'b011;

  typedef struct packed {
    logic            cmpEn;
    logic            pcLoad;
    logic            illegal;
    logic [OP_W-1:0] op;
  } ctrl_strobes_t;
endpackage

// File: rtl/byte_isa_ctrl.sv
`timescale 1ns/1ps
module byte_isa_ctrl
  import byte_isa_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  input  logic              flagQ,
  output ctrl_strobes_t     strobes
);
  logic [OP_W-1:0] opField;
  assign opField = instr[DATA_W-1 -: OP_W];

  always_comb begin
    strobes         = '0;
    strobes.op      = opField;
    unique case (opField)
      OP_CMP:  strobes.cmpEn  = 1'b1;
      OP_JMP:  strobes.pcLoad = ~flagQ;
      OP_NOP:  ;
      default: strobes.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/byte_isa_dp.sv
`timescale 1ns/1ps
module byte_isa_dp
  import byte_isa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrIdx,
  input  logic [DATA_W-1:0] regWrData,
  input  ctrl_strobes_t     strobes,
  output logic [DATA_W-1:0] instr,
  output logic              flagQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic              traceValidQ,
  output logic [ADDR_W-1:0] tracePcQ,
  output logic [OP_W-1:0]   traceOpQ,
  output logic              illegalQ
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [DATA_W-1:0] regQ [NUM_REG];
  logic [DATA_W-1:0] regA, regB;
  logic [ADDR_W-1:0] pcInc, pcNext;
  logic              andZero;

  // Instruction store: write port only, read is combinational
  always_ff @(posedge clk) begin
    if (memWrEn) memQ[memWrAddr] <= memWrData;
  end

  // Register file: one write slot per register
  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (regWrEn && regWrIdx == IDX_W'(g)) regQ[g] <= regWrData;
    end
  end

  assign instr   = memQ[pcQ];
  assign regA    = regQ[instr[4:3]];
  assign regB    = regQ[instr[2:1]];
  assign andZero = ((regA & regB) == '0);
  assign pcInc   = pcQ + ADDR_W'(1);
  assign pcNext  = strobes.pcLoad ? instr[ADDR_W-1:0] : pcInc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ         <= '0;
      flagQ       <= 1'b1;
      traceValidQ <= 1'b0;
      tracePcQ    <= '0;
      traceOpQ    <= '0;
      illegalQ    <= 1'b0;
    end else begin
      pcQ         <= pcNext;
      if (strobes.cmpEn) flagQ <= andZero;
      traceValidQ <= 1'b1;
      tracePcQ    <= pcQ;
      traceOpQ    <= strobes.op;
      illegalQ    <= strobes.illegal;
    end
  end

  // R2: a retired no-op steps the PC by one
  p_nop_step_r2: assert property (@(posedge clk) disable iff (rst)
    (traceValidQ && traceOpQ == OP_NOP) |-> (pcQ == tracePcQ + ADDR_W'(1)));

  // R3: compare flag matches the AND of the operands read before the edge
  p_cmp_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && strobes.cmpEn) |=> (flagQ == $past(andZero)));

  // R4: jump and no-op leave the flag alone
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !strobes.cmpEn) |=> $stable(flagQ));

  // R4: a jump with the flag clear lands on its target
  p_jump_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && strobes.op == OP_JMP && !flagQ) |=> (pcQ == $past(instr[ADDR_W-1:0])));

  // R5: a non-jump at the top address wraps to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (traceValidQ && tracePcQ == '1 && traceOpQ != OP_JMP) |-> (pcQ == '0));

  // R6: the illegal pulse only accompanies an unassigned opcode
  p_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    illegalQ |-> (traceValidQ && traceOpQ != OP_CMP && traceOpQ != OP_JMP && traceOpQ != OP_NOP));
endmodule

// File: rtl/byte_isa_core.sv
`timescale 1ns/1ps
module byte_isa_core
  import byte_isa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        memWrEn,
  input  logic [4:0]  memWrAddr,
  input  logic [7:0]  memWrData,
  input  logic        regWrEn,
  input  logic [1:0]  regWrIdx,
  input  logic [7:0]  regWrData,
  output logic [4:0]  pcNow,
  output logic        flagZero,
  output logic        traceValid,
  output logic [4:0]  tracePc,
  output logic [2:0]  traceOp,
  output logic        illegalOp
);
  ctrl_strobes_t     strobes;
  logic [DATA_W-1:0] instr;
  logic              flagQ;

  byte_isa_ctrl ctrl_i (
    .instr   (instr),
    .flagQ   (flagQ),
    .strobes (strobes)
  );

  byte_isa_dp dp_i (
    .clk         (clk),
    .rst         (rst),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .regWrEn     (regWrEn),
    .regWrIdx    (regWrIdx),
    .regWrData   (regWrData),
    .strobes     (strobes),
    .instr       (instr),
    .flagQ       (flagQ),
    .pcQ         (pcNow),
    .traceValidQ (traceValid),
    .tracePcQ    (tracePc),
    .traceOpQ    (traceOp),
    .illegalQ    (illegalOp)
  );

  assign flagZero = flagQ;
endmodule

// File: tb/byte_isa_core_tb.sv
`timescale 1ns/1ps
module byte_isa_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       memWrEn = 1'b0;
  logic [4:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regWrIdx = '0;
  logic [7:0] regWrData = '0;
  logic [4:0] pcNow;
  logic       flagZero, traceValid, illegalOp;
  logic [4:0] tracePc;
  logic [2:0] traceOp;

  always #2 clk = ~clk;

  byte_isa_core dut_i (
    .clk(clk), .rst(rst),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .pcNow(pcNow), .flagZero(flagZero), .traceValid(traceValid),
    .tracePc(tracePc), .traceOp(traceOp), .illegalOp(illegalOp)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  logic [7:0] mMem [32];
  logic [7:0] mReg [4];
  int mPc, mFlag, mTv, mTpc, mTop, mIll;
  string tag;

  task automatic modelStep();
    int ins, op;
    ins = int'(mMem[mPc]);
    op  = ins >> 5;
    if (rst) begin
      mPc = 0; mFlag = 1; mTv = 0; mTpc = 0; mTop = 0; mIll = 0;
      tag = "R1";
    end else begin
      mTv = 1; mTpc = mPc; mTop = op; mIll = 0;
      if (op == 1) begin
        mFlag = ((mReg[(ins >> 3) & 3] & mReg[(ins >> 1) & 3]) == 8'd0) ? 1 : 0;
        mPc = (mPc + 1) % 32; tag = "R3";
      end else if (op == 2) begin
        mPc = (mFlag == 0) ? (ins & 31) : (mPc + 1) % 32; tag = "R4";
      end else if (op == 3) begin
        mPc = (mPc + 1) % 32; tag = (mTpc == 31) ? "R5" : "R2";
      end else begin
        mPc = (mPc + 1) % 32; mIll = 1; tag = "R6";
      end
    end
    if (memWrEn || regWrEn) tag = "R7";
    // writes land after operands were read
    if (memWrEn) mMem[memWrAddr] = memWrData;
    if (regWrEn) mReg[regWrIdx] = regWrData;
  endtask

  task automatic compareAll();
    logic [15:0] got, exp;
    got = {pcNow, flagZero, traceValid, tracePc, traceOp, illegalOp};
    exp = {5'(mPc), 1'(mFlag), 1'(mTv), 5'(mTpc), 3'(mTop), 1'(mIll)};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h (pc,flag,tv,tpc,top,ill)", tag, got, exp);
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    memWrEn = 1'b0;
    regWrEn = 1'b0;
  endtask

  task automatic setMem(input int a, input int d);
    memWrEn = 1'b1; memWrAddr = 5'(a); memWrData = 8'(d);
    tick();
  endtask

  task automatic setReg(input int i, input int d);
    regWrEn = 1'b1; regWrIdx = 2'(i); regWrData = 8'(d);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    // R1: preload during reset; every tick checks the reset values
    for (int a = 0; a < 32; a++) setMem(a, 8'h60);
    setMem(0,  8'h24); // cmp r0 r2 -> nonzero (R3)
    setMem(1,  8'h45); // jmp 5, taken (R4)
    setMem(5,  8'h22); // cmp r0 r1 -> zero
    setMem(6,  8'h42); // jmp 2, not taken (R4)
    setMem(7,  8'h00); // illegal 000 (R6)
    setMem(8,  8'hE0); // illegal 111 (R6)
    setMem(9,  8'h9F); // illegal 100 (R6)
    setMem(10, 8'h3E); // cmp r3 r3 -> nonzero
    setMem(11, 8'h5E); // jmp 30, taken
    setReg(0, 8'h0F);
    setReg(1, 8'hF0);
    setReg(2, 8'h3C);
    setReg(3, 8'h01);
    rst = 1'b0;
    // R2..R6: scripted path 0,1,5,6,7..11,30,31,0 wraps (R5)
    repeat (14) tick();
    // R7: rewrite r1 on the edge where cmp r0 r1 at address 5 retires
    while (pcNow != 5'd5) tick();
    regWrEn = 1'b1; regWrIdx = 2'd1; regWrData = 8'hFF;
    tick();
    repeat (20) tick();
    // R7: overwrite the byte under the PC while it is fetched
    memWrEn = 1'b1; memWrAddr = pcNow; memWrData = 8'hA0;
    tick();
    repeat (40) tick();

    // Random phase with writes landing during execution
    rst = 1'b1;
    for (int a = 0; a < 32; a++) setMem(a, int'($urandom_range(0, 255)));
    for (int i = 0; i < 4; i++) setReg(i, int'($urandom_range(0, 255)));
    rst = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 7) == 0) begin
        memWrEn = 1'b1;
        memWrAddr = ($urandom_range(0, 1) == 0) ? pcNow : 5'($urandom_range(0, 31));
        memWrData = 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 5) == 0) begin
        regWrEn = 1'b1;
        regWrIdx = 2'($urandom_range(0, 3));
        regWrData = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      end
      if (c == 1500) rst = 1'b1;
      if (c == 1503) rst = 1'b0;
      tick();
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule